// File: doc/BRIEF.md
# UART Transmitter with Clear-to-Send Gating and Automatic Request-to-Send Release

This block serialises characters from a small transmit FIFO onto an asynchronous line. It is paced by a 16x oversampling tick, or in 1x mode by one tick per bit. It sends 5 to 8 data bits LSB first, with optional even or odd parity. The stop interval is set in sixteenths of a bit, and the 4-bit stop code is decoded differently for 5-bit characters. Once a character has been sent, the next one can start on the very tick at which the stop interval ends.

Two flow-control aids are built in. With the clear-to-send gate on, the active-low `cts_n` input is looked at only when a character is about to start. While it is high the line stays at mark. A change in the middle of a character does not touch that character. The request-to-send latch is normally set and cleared by software pulses and drives the active-low `rts_n` pin. With automatic release on, the latch is cleared one bit time after the line drains, provided the transmitter has been disabled. Characters already in the FIFO still go out after the disable, so a message can be queued, the transmitter disabled, and the line turned around by hardware.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset `txd` is 1, `rts_n` is 1 and `fifo_full` is 0.
- R2: A character is a low start bit, then `char_len`+5 data bits LSB first (char_len 0..3 selects 5..8 bits). With `x1_mode`=0 each bit lasts 16 ticks.
- R3: With `par_en`=1 a parity bit follows the data. With `par_odd`=0 the data and parity bits together hold an even number of ones; with `par_odd`=1 they hold an odd number.
- R4: With 6, 7 or 8 data bits and `x1_mode`=0, the stop interval is 9+`stop_sel` ticks for codes 0..7 and 17+`stop_sel` ticks for codes 8..15.
- R5: With 5 data bits and `x1_mode`=0, the stop interval is 17+`stop_sel` ticks.
- R6: With `x1_mode`=1 each start, data and parity bit lasts one tick. The stop interval is 1 tick when `stop_sel[3]`=0 and 2 ticks when it is 1.
- R7: With `cts_gate`=1 and `cts_n`=1, no character starts and `txd` stays 1. A character starts once `cts_n` goes low.
- R8: A change of `cts_n` while a character is being sent leaves that character unchanged.
- R9: The FIFO holds DEPTH characters. `fifo_full` is 1 when it is full, and a write while full is dropped. Queued characters go out back to back, with a stop interval of exactly the programmed length.
- R10: A `rts_set` pulse drives `rts_n` to 0 and a `rts_clr` pulse drives it to 1. When both pulses arrive in the same cycle, set wins.
- R11: With `rts_auto`=1 and the transmitter disabled, the characters already queued still drain. `rts_n` then rises 16 ticks after the end of the last stop interval: the tick-indexed line sample at offset 16 past the frames shows 1 and the sample at offset 15 shows 0.
- R12: An accepted write or an `en_set` during the release delay cancels the release. This holds even when it falls on the tick at which the release would take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling tick (one per bit in 1x mode) |
| x1_mode | input | 1 | 1 = one tick per bit |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 = odd parity |
| stop_sel | input | 4 | Stop interval code |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | Character to queue |
| fifo_full | output | 1 | FIFO full |
| en_set | input | 1 | Enable transmitter pulse |
| en_clr | input | 1 | Disable transmitter pulse |
| cts_gate | input | 1 | Clear-to-send gating enable |
| cts_n | input | 1 | Clear to send, active low |
| rts_auto | input | 1 | Automatic request-to-send release enable |
| rts_set | input | 1 | Software set of request-to-send latch |
| rts_clr | input | 1 | Software clear of request-to-send latch |
| rts_n | output | 1 | Request to send, active low |
| txd | output | 1 | Serial output |

## Verification
The automatic release and a FIFO write can land on the same tick: the tick at which the 16-tick delay expires. The bench counts line samples per tick to find that exact cycle, then drives a write there. It judges the result by `rts_n` staying low at the sample where the release would have appeared, and by a fresh release 16 ticks after the new character drains. A second collision pairs software set and clear in one cycle, and the bench expects the latch to stay asserted.

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       x1_mode,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [3:0] stop_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       fifo_full,
  input  logic       en_set,
  input  logic       en_clr,
  input  logic       cts_gate,
  input  logic       cts_n,
  input  logic       rts_auto,
  input  logic       rts_set,
  input  logic       rts_clr,
  output logic       rts_n,
  output logic       txd
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t st;

  logic [7:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;
  logic [5:0]  tcnt, stop_last;
  logic [2:0]  bidx;
  logic [7:0]  sh;
  logic        par, tx_en, rts_q, rel_done;
  logic [3:0]  rel_cnt;

  wire empty  = (cnt == '0);
  assign fifo_full = (cnt == (AW+1)'(DEPTH));
  wire push   = wr_en && !fifo_full;
  wire cts_ok = !cts_gate || !cts_n;

  wire [5:0] bit_last = x1_mode ? 6'd0 : 6'd15;
  wire [3:0] rel_last = x1_mode ? 4'd0 : 4'd15;
  wire [2:0] nb_last  = 3'd4 + {1'b0, char_len};
  wire [7:0] mask     = 8'hFF >> (2'd3 - char_len);
  wire [7:0] head     = mem[rp];

  always_comb begin
    if (x1_mode)                          stop_last = {5'd0, stop_sel[3]};
    else if (char_len == 2'd0 || stop_sel[3]) stop_last = 6'd16 + {2'b0, stop_sel};
    else                                  stop_last = 6'd8 + {2'b0, stop_sel};
  end

  wire [5:0] cur_last = (st == S_STOP) ? stop_last : bit_last;
  wire launch = tick && !empty && cts_ok &&
                (st == S_IDLE || (st == S_STOP && tcnt == stop_last));

  assign txd = (st == S_START) ? 1'b0 :
               (st == S_DATA)  ? sh[0] :
               (st == S_PAR)   ? par : 1'b1;

  always_ff @(posedge clk) if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push)   wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (launch) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (push && !launch)      cnt <= cnt + 1'b1;
      else if (!push && launch) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; bidx <= '0; sh <= '0; par <= 1'b0;
    end else if (launch) begin
      st <= S_START; tcnt <= '0; sh <= head;
      par <= (^(head & mask)) ^ par_odd;
    end else if (tick && st != S_IDLE) begin
      if (tcnt != cur_last) tcnt <= tcnt + 6'd1;
      else begin
        tcnt <= '0;
        case (st)
          S_START: begin st <= S_DATA; bidx <= '0; end
          S_DATA: begin
            sh <= sh >> 1;
            bidx <= bidx + 3'd1;
            if (bidx == nb_last) st <= par_en ? S_PAR : S_STOP;
          end
          S_PAR:   st <= S_STOP;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  wire rel_base = rts_auto && !tx_en && st == S_IDLE && empty;
  wire rel_hit  = rel_base && !rel_done && tick && rel_cnt == rel_last;
  wire rel_fire = rel_hit && !push && !en_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0; rts_q <= 1'b0; rel_done <= 1'b0; rel_cnt <= '0;
    end else begin
      if (en_set)      tx_en <= 1'b1;
      else if (en_clr) tx_en <= 1'b0;
      if (rts_set)                rts_q <= 1'b1;
      else if (rts_clr || rel_fire) rts_q <= 1'b0;
      if (!rel_base) begin
        rel_cnt <= '0; rel_done <= 1'b0;
      end else if (rel_hit) begin
        rel_cnt <= '0; rel_done <= 1'b1;
      end else if (tick && !rel_done) rel_cnt <= rel_cnt + 4'd1;
    end
  end

  assign rts_n = ~rts_q;

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  assert_cts_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cts_gate && cts_n) |=> st == S_IDLE);
  assert_start_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START) |=> (st == S_START || st == S_DATA));
  assert_rts_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_q) |-> $past(rts_set));
  assert_release_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rts_q) && !$past(rts_clr)) |-> $past(rts_auto && !tx_en && empty && st == S_IDLE));
  assert_cancel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !rts_clr) |=> !$fell(rts_q));
endmodule

// File: tb/uart_tx_flow_tb.sv
module uart_tx_flow_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic x1_mode = 0, par_en = 0, par_odd = 0, wr_en = 0;
  logic [1:0] char_len = 2'd3;
  logic [3:0] stop_sel = 4'd7;
  logic [7:0] wr_data = 0;
  logic en_set = 0, en_clr = 0, cts_gate = 0, cts_n = 0;
  logic rts_auto = 0, rts_set = 0, rts_clr = 0;
  logic fifo_full, rts_n, txd, tick;
  int unsigned cyc = 0;
  int nent = 0, n_chk = 0, n_fail = 0;
  bit line_q[$], rq[$], exp_q[$];

  uart_tx_flow #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .x1_mode(x1_mode), .char_len(char_len),
    .par_en(par_en), .par_odd(par_odd), .stop_sel(stop_sel), .wr_en(wr_en),
    .wr_data(wr_data), .fifo_full(fifo_full), .en_set(en_set), .en_clr(en_clr),
    .cts_gate(cts_gate), .cts_n(cts_n), .rts_auto(rts_auto), .rts_set(rts_set),
    .rts_clr(rts_clr), .rts_n(rts_n), .txd(txd));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick = cyc[0];

  always @(negedge clk) if (rst_n && !cyc[0]) begin
    line_q.push_back(txd); rq.push_back(rts_n); nent++;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int stop_len(logic [3:0] c, int nb, bit x1);
    if (x1) return c[3] ? 2 : 1;
    if (nb == 5 || c[3]) return 17 + int'(c);
    return 9 + int'(c);
  endfunction

  task automatic add_frame(logic [7:0] d);
    int bl = x1_mode ? 1 : 16;
    int nb = int'(char_len) + 5;
    bit p = par_odd;
    for (int k = 0; k < bl; k++) exp_q.push_back(1'b0);
    for (int i = 0; i < nb; i++) begin
      p ^= d[i];
      for (int k = 0; k < bl; k++) exp_q.push_back(d[i]);
    end
    if (par_en) for (int k = 0; k < bl; k++) exp_q.push_back(p);
    for (int k = 0; k < stop_len(stop_sel, nb, x1_mode); k++) exp_q.push_back(1'b1);
  endtask

  task automatic ticks(int n); repeat (2*n) @(negedge clk); endtask
  task automatic clear_line; line_q.delete(); rq.delete(); exp_q.delete(); endtask
  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d; @(negedge clk); wr_en = 0;
  endtask
  task automatic pulse(ref logic s); @(negedge clk); s = 1; @(negedge clk); s = 0; endtask

  function automatic int first_low(int from);
    for (int i = from; i < line_q.size(); i++) if (line_q[i] == 1'b0) return i;
    return -1;
  endfunction

  task automatic compare(string req, string what);
    int s = first_low(0);
    int bad = -1;
    if (s < 0) bad = 0;
    else begin
      for (int i = 0; i < exp_q.size(); i++)
        if (s + i >= line_q.size() || line_q[s+i] != exp_q[i]) begin bad = i; break; end
      if (bad < 0)
        for (int i = s + exp_q.size(); i < line_q.size(); i++)
          if (line_q[i] != 1'b1) begin bad = i - s; break; end
    end
    check(bad < 0, req, what, bad, -1);
  endtask

  task automatic mode(bit x1, logic [1:0] cl, bit pe, bit po, logic [3:0] ss);
    @(negedge clk); x1_mode = x1; char_len = cl; par_en = pe; par_odd = po; stop_sel = ss;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s, L, r;
    logic [7:0] d;
    r = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    check(txd == 1, "R1", "txd after reset", txd, 1);
    check(rts_n == 1, "R1", "rts_n after reset", rts_n, 1);
    check(fifo_full == 0, "R1", "fifo_full after reset", fifo_full, 0);
    rst_n = 1;
    ticks(4);

    mode(0, 3, 0, 0, 7); clear_line; wr(8'hA5); add_frame(8'hA5);
    ticks(exp_q.size() + 40); compare("R2", "8N frame 0xA5");
    mode(0, 2, 1, 0, 7); clear_line; wr(8'h35); add_frame(8'h35);
    ticks(exp_q.size() + 40); compare("R3", "7-bit even parity");
    mode(0, 2, 1, 1, 7); clear_line; wr(8'h35); add_frame(8'h35);
    ticks(exp_q.size() + 40); compare("R3", "7-bit odd parity");
    mode(0, 1, 0, 0, 0); clear_line; wr(8'h2D); wr(8'h12); add_frame(8'h2D); add_frame(8'h12);
    ticks(exp_q.size() + 40); compare("R4", "stop code 0 back to back");
    mode(0, 3, 0, 0, 15); clear_line; wr(8'h80); wr(8'h01); add_frame(8'h80); add_frame(8'h01);
    ticks(exp_q.size() + 40); compare("R4", "stop code 15 back to back");
    mode(0, 0, 0, 0, 0); clear_line; wr(8'h13); wr(8'h0C); add_frame(8'h13); add_frame(8'h0C);
    ticks(exp_q.size() + 40); compare("R5", "5-bit stop code 0");
    mode(1, 3, 1, 0, 8); clear_line; wr(8'h6B); wr(8'h94); add_frame(8'h6B); add_frame(8'h94);
    ticks(exp_q.size() + 40); compare("R6", "1x two stop bits");
    mode(1, 1, 0, 0, 7); clear_line; wr(8'h15); wr(8'h2A); add_frame(8'h15); add_frame(8'h2A);
    ticks(exp_q.size() + 40); compare("R6", "1x one stop bit");

    mode(0, 3, 0, 0, 7);
    @(negedge clk); cts_gate = 1; cts_n = 1;
    clear_line; wr(8'h81); ticks(100);
    check(first_low(0) < 0, "R7", "low sample while CTS high", first_low(0), -1);
    @(negedge clk); cts_n = 0; add_frame(8'h81);
    ticks(exp_q.size() + 40); compare("R7", "frame after CTS low");
    clear_line; wr(8'h3C); add_frame(8'h3C); ticks(40);
    @(negedge clk); cts_n = 1; ticks(200);
    compare("R8", "CTS rise mid-character");
    @(negedge clk); cts_n = 0; ticks(2);

    @(negedge clk); cts_n = 1; clear_line;
    for (int i = 0; i < DEPTH; i++) begin wr(8'h11 * (i + 1)); add_frame(8'h11 * (i + 1)); end
    @(negedge clk);
    check(fifo_full == 1, "R9", "fifo_full at DEPTH", fifo_full, 1);
    wr(8'hEE);
    @(negedge clk);
    check(fifo_full == 1, "R9", "fifo_full after extra write", fifo_full, 1);
    cts_n = 0;
    ticks(exp_q.size() + 60); compare("R9", "DEPTH frames, extra dropped");
    check(fifo_full == 0, "R9", "fifo_full after drain", fifo_full, 0);
    @(negedge clk); cts_gate = 0;

    pulse(rts_set);
    check(rts_n == 0, "R10", "rts_n after set", rts_n, 0);
    @(negedge clk); rts_set = 1; rts_clr = 1; @(negedge clk); rts_set = 0; rts_clr = 0;
    check(rts_n == 0, "R10", "set wins over clear", rts_n, 0);
    pulse(rts_clr);
    check(rts_n == 1, "R10", "rts_n after clear", rts_n, 1);

    @(negedge clk); rts_auto = 1;
    pulse(en_set); pulse(rts_set); clear_line;
    wr(8'h5A); wr(8'hC3); pulse(en_clr);
    add_frame(8'h5A); add_frame(8'hC3); L = exp_q.size();
    ticks(L + 40);
    compare("R11", "drain after disable");
    s = first_low(0);
    check(s >= 0 && rq[s+L+15] == 0, "R11", "rts_n one tick before release", s >= 0 ? int'(rq[s+L+15]) : -1, 0);
    check(s >= 0 && rq[s+L+16] == 1, "R11", "rts_n at release tick", s >= 0 ? int'(rq[s+L+16]) : -1, 1);

    pulse(rts_set); pulse(en_set); pulse(en_clr); clear_line;
    wr(8'h47); exp_q.delete(); add_frame(8'h47); L = exp_q.size();
    ticks(10); s = first_low(0);
    wait (nent >= 0 && line_q.size() >= s + L + 16);
    @(negedge clk); wr_en = 1; wr_data = 8'h0F; @(negedge clk); wr_en = 0;
    ticks(L + 40);
    check(rq[s+L+16] == 0, "R12", "write on release tick cancels", int'(rq[s+L+16]), 0);
    s = first_low(s + L);
    check(s >= 0 && rq[s+L+15] == 0 && rq[s+L+16] == 1, "R12", "release after new drain",
          s >= 0 ? int'(rq[s+L+16]) : -1, 1);

    pulse(rts_set); clear_line; wr(8'h99);
    ticks(L + 10); pulse(en_set); ticks(40);
    check(rts_n == 0, "R12", "enable during delay cancels", rts_n, 0);
    pulse(en_clr); ticks(20);
    check(rts_n == 1, "R11", "release after disable", rts_n, 1);
    @(negedge clk); rts_auto = 0;

    for (int it = 0; it < 20; it++) begin
      int n = 1 + int'($urandom_range(0, 2));
      mode(($urandom_range(0, 4) == 0), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
      clear_line;
      for (int k = 0; k < n; k++) begin d = 8'($urandom); wr(d); add_frame(d); end
      ticks(exp_q.size() + 48);
      compare(char_len == 0 ? "R5" : "R4", "random frames");
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule